// File: doc/BRIEF.md
# Frame-Synchronised Power-Down Sequencer

This block controls when an audio processing core enters and leaves a clock-stopped sleep state. An external sleep request pin is not acted on at once. The block looks at it only on selected rising edges of the audio frame clock: one edge in every N, where N comes from a programmable count. Once it sees a request, it lets any soft volume ramp that is in progress finish. It then waits a fixed number of processor clock cycles and drops the enable of the core clock gate. Register contents survive because the block only withholds clocks and clears nothing.

Wake-up works the same way. A released pin is noticed at the next sampling point. The core clocks come back, and a one-cycle resume strobe is raised, only on the following rising frame-clock edge. The data path therefore restarts on a fresh audio sample. The sampling counter, the synchronisers and the sequencer all run on the free-running processor clock, which is never gated. If the request disappears before the clocks are gated, the block abandons the entry.

Top module: `frame_pwrdn_ctrl`

## Requirements
- R1: The active-low reset `rstN` acts asynchronously. While it is low, and after it is released, `pdState` is 0 (running), `coreClkEn` is 1 and `resumeStrobe` is 0.
- R2: `sleepReq` is taken into account only on every effective-N-th rising edge of `frameClk`, counted from reset. Its level at any other time has no effect.
- R3: A `frameCount` value of 0 behaves exactly like 1: the request is sampled on every rising frame edge.
- R4: If a request is recognised while `rampBusy` is low, `pdState` goes to 2 (delay). If `rampBusy` is high, `pdState` goes to 1 (ramp pending) and stays there until `rampBusy` falls, then goes to 2.
- R5: `pdState` stays at 2 for exactly DELAY_CYCLES clock cycles and then becomes 3 (down). In that same cycle `coreClkEn` goes low.
- R6: In state 3, rising frame edges that are not sampling points leave the state unchanged. A release seen at a sampling point moves `pdState` to 4 (waiting for a frame), with `coreClkEn` still low.
- R7: From state 4, the next rising frame edge returns `pdState` to 0. In that cycle `coreClkEn` rises and `resumeStrobe` is high for exactly one cycle.
- R8: A release recognised in state 1 or state 2 returns `pdState` to 0 without `coreClkEn` ever going low.
- R9: `coreClkEn` is low exactly when `pdState` is 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running processor clock, never gated |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Asynchronous sleep request pin, high asks for sleep |
| frameClk | input | 1 | Asynchronous audio frame clock |
| frameCount | input | CNT_W | Number of frame periods between request samples (0 means 1) |
| rampBusy | input | 1 | High while a soft volume ramp is running (clk domain) |
| coreClkEn | output | 1 | Enable for the core clock gate, high while clocks run |
| resumeStrobe | output | 1 | One-cycle pulse when processing restarts on a frame edge |
| pdState | output | 3 | Sequencer state: 0 run, 1 ramp pending, 2 delay, 3 down, 4 wait frame |

## Verification
The bench sweeps several sampling intervals, including zero. For each one it checks that the state leaves running on exactly the N-th edge and not before. A counter that restarted wrongly, or that treated zero as 256, would leave running early, late or never. The bench also checks that the delay state lasts exactly the configured number of cycles, since an off-by-one counter shows up directly in that run length. It aborts an entry from both the ramp-pending and the delay state and confirms that the clock enable never dropped, because a design that gated the clocks before checking the release would fail there. A short request pulse that falls before the sampling edge must be ignored. Wake-up must wait for the frame edge after the release and give exactly one resume pulse.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [2:0] {
    PD_RUN   = 3'd0,
    PD_PEND  = 3'd1,
    PD_DELAY = 3'd2,
    PD_DOWN  = 3'd3,
    PD_WAIT  = 3'd4
  } pdState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic delayLoad;
    logic delayStep;
  } ctrlStrobe_t;

  // status from the datapath back to the sequencer
  typedef struct packed {
    logic reqSeen;
    logic frameRise;
    logic delayDone;
  } dpStatus_t;

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pd_seq_datapath.sv
module pd_seq_datapath
  import pd_seq_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int DELAY_CYCLES = 80,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             frameClk,
  input  logic [CNT_W-1:0] frameCount,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status
);
  localparam int DLY_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY_CYCLES - 1);

  logic             lrSync, reqSync, lrPrev;
  logic             frameRise, lastFrame, sampleTick;
  logic [CNT_W-1:0] effN, frmCnt;
  logic             reqLatched;
  logic [DLY_W-1:0] delayCnt;

  pd_sync #(.STAGES(SYNC_STAGES)) i_syncFrame (
    .clk(clk), .rstN(rstN), .din(frameClk), .dout(lrSync)
  );
  pd_sync #(.STAGES(SYNC_STAGES)) i_syncReq (
    .clk(clk), .rstN(rstN), .din(sleepReq), .dout(reqSync)
  );

  // rising edge of the synchronised frame clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lrPrev <= 1'b0;
    else       lrPrev <= lrSync;
  end
  assign frameRise = lrSync & ~lrPrev;

  // sampling interval, zero folded to one
  assign effN       = (frameCount == '0) ? CNT_W'(1) : frameCount;
  assign lastFrame  = (frmCnt >= effN - CNT_W'(1));
  assign sampleTick = frameRise & lastFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmCnt     <= '0;
      reqLatched <= 1'b0;
    end else begin
      if (frameRise) frmCnt <= lastFrame ? '0 : frmCnt + CNT_W'(1);
      if (sampleTick) reqLatched <= reqSync;
    end
  end

  // entry delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                delayCnt <= '0;
    else if (strobe.delayLoad)                delayCnt <= DLY_LOAD;
    else if (strobe.delayStep && delayCnt != '0) delayCnt <= delayCnt - DLY_W'(1);
  end

  assign status.reqSeen   = reqLatched;
  assign status.frameRise = frameRise;
  assign status.delayDone = (delayCnt == '0);
endmodule

// File: rtl/pd_seq_control.sv
module pd_seq_control
  import pd_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rampBusy,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output pdState_e    state,
  output logic        coreClkEn,
  output logic        resumeStrobe
);
  pdState_e nextState;
  logic     nextOff;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      PD_RUN: begin
        if (status.reqSeen) begin
          if (rampBusy) nextState = PD_PEND;
          else begin
            nextState        = PD_DELAY;
            strobe.delayLoad = 1'b1;
          end
        end
      end
      PD_PEND: begin
        if (!status.reqSeen) nextState = PD_RUN;
        else if (!rampBusy) begin
          nextState        = PD_DELAY;
          strobe.delayLoad = 1'b1;
        end
      end
      PD_DELAY: begin
        strobe.delayStep = 1'b1;
        if (!status.reqSeen)       nextState = PD_RUN;
        else if (status.delayDone) nextState = PD_DOWN;
      end
      PD_DOWN: begin
        if (!status.reqSeen) nextState = PD_WAIT;
      end
      PD_WAIT: begin
        if (status.frameRise) nextState = PD_RUN;
      end
      default: nextState = PD_RUN;
    endcase
  end

  assign nextOff = (nextState == PD_DOWN) || (nextState == PD_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= PD_RUN;
      coreClkEn    <= 1'b1;
      resumeStrobe <= 1'b0;
    end else begin
      state        <= nextState;
      coreClkEn    <= ~nextOff;
      resumeStrobe <= (state == PD_WAIT) && (nextState == PD_RUN);
    end
  end
endmodule

// File: rtl/frame_pwrdn_ctrl.sv
module frame_pwrdn_ctrl
  import pd_seq_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int DELAY_CYCLES = 80,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             frameClk,
  input  logic [CNT_W-1:0] frameCount,
  input  logic             rampBusy,
  output logic             coreClkEn,
  output logic             resumeStrobe,
  output logic [2:0]       pdState
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  pdState_e    state;

  pd_seq_datapath #(
    .CNT_W(CNT_W), .DELAY_CYCLES(DELAY_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .frameClk(frameClk),
    .frameCount(frameCount), .strobe(strobe), .status(status)
  );

  pd_seq_control i_control (
    .clk(clk), .rstN(rstN), .rampBusy(rampBusy), .status(status),
    .strobe(strobe), .state(state), .coreClkEn(coreClkEn),
    .resumeStrobe(resumeStrobe)
  );

  assign pdState = state;
endmodule

// File: rtl/pd_seq_checker.sv
module pd_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rampBusy,
  input logic       coreClkEn,
  input logic       resumeStrobe,
  input logic [2:0] pdState
);
  assert_clk_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn == !(pdState == 3'd3 || pdState == 3'd4));

  assert_strobe_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    resumeStrobe |-> (pdState == 3'd0 && $past(pdState) == 3'd4));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    resumeStrobe |=> !resumeStrobe);

  assert_down_from_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pdState == 3'd3) |-> ($past(pdState) == 3'd2 || $past(pdState) == 3'd3));

  assert_wait_from_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pdState == 3'd4) |-> ($past(pdState) == 3'd3 || $past(pdState) == 3'd4));

  assert_pend_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pdState == 3'd2 && $past(pdState) == 3'd1) |-> !$past(rampBusy));

  assert_abort_no_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pdState == 3'd0 && ($past(pdState) == 3'd1 || $past(pdState) == 3'd2))
      |-> $past(coreClkEn) && coreClkEn);

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    pdState <= 3'd4);
endmodule

bind frame_pwrdn_ctrl pd_seq_checker i_pdSeqChecker (
  .clk(clk), .rstN(rstN), .rampBusy(rampBusy), .coreClkEn(coreClkEn),
  .resumeStrobe(resumeStrobe), .pdState(pdState)
);

// File: tb/test_frame_pwrdn_ctrl.sv
module test_frame_pwrdn_ctrl;
  localparam int CNT_W = 4;
  localparam int DLY   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic frameClk = 1'b0;
  logic [CNT_W-1:0] frameCount = '0;
  logic rampBusy = 1'b0;
  logic coreClkEn, resumeStrobe;
  logic [2:0] pdState;

  int testCount = 0;
  int failCount = 0;
  int runCur = 0, lastDelayRun = 0, clkOffCount = 0, strobeCount = 0;

  always #4 clk = ~clk;

  frame_pwrdn_ctrl #(.CNT_W(CNT_W), .DELAY_CYCLES(DLY), .SYNC_STAGES(2)) i_frame_pwrdn_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .frameClk(frameClk),
    .frameCount(frameCount), .rampBusy(rampBusy), .coreClkEn(coreClkEn),
    .resumeStrobe(resumeStrobe), .pdState(pdState)
  );

  // output monitor
  always @(negedge clk) begin
    if (!rstN) begin
      runCur = 0; lastDelayRun = 0; clkOffCount = 0; strobeCount = 0;
    end else begin
      if (pdState == 3'd2) runCur++;
      else if (runCur != 0) begin lastDelayRun = runCur; runCur = 0; end
      if (!coreClkEn) clkOffCount++;
      if (resumeStrobe) strobeCount++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frameEdge();
    @(negedge clk) frameClk = 1'b1;
    repeat (4) @(negedge clk);
    frameClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitDown();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pdState == 3'd3) break;
    end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0] n;
    logic       ramp;
    logic [3:0] edges;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd0, 1'b0, 4'd1},
    '{4'd1, 1'b1, 4'd1},
    '{4'd3, 1'b0, 4'd3},
    '{4'd5, 1'b1, 4'd5},
    '{4'd2, 1'b0, 4'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // table-driven full sleep/wake cycles
    for (int v = 0; v < 5; v++) begin
      doReset();
      check(pdState == 3'd0, "R1 reset state", pdState, 0);
      check(coreClkEn == 1'b1 && resumeStrobe == 1'b0, "R1 reset outputs", coreClkEn, 1);
      frameCount = VECS[v].n;
      rampBusy   = VECS[v].ramp;
      sleepReq   = 1'b1;
      for (int e = 1; e <= int'(VECS[v].edges); e++) begin
        frameEdge();
        if (e < int'(VECS[v].edges))
          check(pdState == 3'd0, "R2 before sample edge", pdState, 0);
        else if (VECS[v].n == 0)
          check(pdState == 3'd2, "R3 zero count samples every frame", pdState, 2);
        else
          check(pdState == (VECS[v].ramp ? 3'd1 : 3'd2), "R4 recognised entry state",
                pdState, VECS[v].ramp ? 1 : 2);
      end
      if (VECS[v].ramp) begin
        repeat (30) @(negedge clk);
        check(pdState == 3'd1, "R4 held while ramp busy", pdState, 1);
        rampBusy = 1'b0;
      end
      waitDown();
      check(lastDelayRun == DLY, "R5 delay length", lastDelayRun, DLY);
      check(pdState == 3'd3 && coreClkEn == 1'b0, "R9 clocks off when down", coreClkEn, 0);
      sleepReq = 1'b0;
      for (int e = 1; e <= int'(VECS[v].edges); e++) begin
        frameEdge();
        if (e < int'(VECS[v].edges))
          check(pdState == 3'd3, "R6 stays down between samples", pdState, 3);
        else
          check(pdState == 3'd4 && coreClkEn == 1'b0, "R6 release to wait frame", pdState, 4);
      end
      begin
        int sc;
        sc = strobeCount;
        frameEdge();
        check(pdState == 3'd0 && coreClkEn == 1'b1, "R7 resume on frame edge", pdState, 0);
        check(strobeCount == sc + 1, "R7 single resume strobe", strobeCount - sc, 1);
      end
    end

    // short request that is gone at the sampling edge
    doReset();
    frameCount = 4'd3; rampBusy = 1'b0; sleepReq = 1'b1;
    frameEdge(); frameEdge();
    sleepReq = 1'b0;
    frameEdge();
    repeat (4) @(negedge clk);
    check(pdState == 3'd0, "R2 pulse between samples ignored", pdState, 0);
    check(clkOffCount == 0, "R2 clocks never stopped", clkOffCount, 0);

    // abort from ramp pending
    doReset();
    frameCount = 4'd1; rampBusy = 1'b1; sleepReq = 1'b1;
    frameEdge();
    check(pdState == 3'd1, "R8 reached ramp pending", pdState, 1);
    sleepReq = 1'b0;
    frameEdge();
    check(pdState == 3'd0, "R8 abort from ramp pending", pdState, 0);
    check(clkOffCount == 0, "R8 no gating on pending abort", clkOffCount, 0);
    rampBusy = 1'b0;

    // abort from delay
    doReset();
    frameCount = 4'd1; sleepReq = 1'b1;
    frameEdge();
    check(pdState == 3'd2, "R8 reached delay", pdState, 2);
    sleepReq = 1'b0;
    frameEdge();
    check(pdState == 3'd0, "R8 abort from delay", pdState, 0);
    check(clkOffCount == 0, "R8 no gating on delay abort", clkOffCount, 0);

    // asynchronous reset while down
    doReset();
    frameCount = 4'd1; sleepReq = 1'b1;
    frameEdge();
    waitDown();
    check(pdState == 3'd3, "R1 reached down before reset", pdState, 3);
    @(posedge clk);
    #2 rstN = 1'b0;
    #1;
    check(pdState == 3'd0 && coreClkEn == 1'b1, "R1 async reset clears down", pdState, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(pdState == 3'd0 && coreClkEn == 1'b1, "R1 running after reset release", pdState, 0);
    sleepReq = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule